// File: doc/BRIEF.md
# Byte-Counted DMA Sideband Signalling Engine

This engine sits beside a storage-card data port and tells a DMA engine where the data it moves falls into blocks and transactions. On a card read the peripheral produces data. Each produced byte is shown to the engine as a one-cycle strobe. The engine counts these strobes against two programmed lengths, a block length and a transaction length. It raises a one-cycle block-end pulse at every block boundary. It raises a one-cycle transaction-end pulse when the whole transfer is complete, if software has enabled that pulse. On a card write the engine plays the consumer role. A start trigger makes the consumer side busy, and it counts consumed-byte strobes until the transaction length is reached.

Software controls the engine through a small word-addressed register file. The file holds the configuration, an idle status word, a software reset, separate start triggers for the producer and the consumer, the two lengths, a live tracker of the producer counters, a pipe-identifier word and two logical pipe-size words. Each side has two flow-control request lines. Configuration chooses which of the two lines, if either, is raised while that side is busy.

Each side is a two-state machine, IDLE and RUN. The producer goes from IDLE to RUN on a producer-start write, which also clears its counters. It stays in RUN while it counts bytes, and it goes from RUN to IDLE on the byte that completes the transaction. The consumer goes from IDLE to RUN on a consumer-start write and from RUN to IDLE on its final consumed byte. A software-reset write sends both machines from either state back to IDLE.

Top module: `sband_engine`

## Requirements
- R1: After the hardware reset, reads return the following values. Status (word 1) reads 0x0001_0001. Config (word 0), block size (word 5), transaction size (word 6), tracker (word 7) and pipe-ID (word 8) read 0. Both pipe-size words (words 9 and 10) read 4096.
- R2: The word index on reg_addr selects the register: 0 config, 1 status, 2 soft reset, 3 producer start, 4 consumer start, 5 block size, 6 transaction size, 7 tracker, 8 pipe-ID, 9 producer pipe size, 10 consumer pipe size. Config keeps only bits [4:0] and [18:16]. Pipe-ID keeps only bits [4:0] and [20:16]. The lengths and pipe sizes keep bits [15:0]. All other bits read 0.
- R3: A producer-start write received while the producer is idle clears both producer counters and makes status bit 0 read 0. From then on, every cycle with prod_byte high counts one byte.
- R4: blk_end is high for exactly one cycle. That cycle is the clock cycle after the byte strobe that brings the block count up to the block size. The block count then wraps to 0. A block size of 0 never produces blk_end.
- R5: The producer returns to idle (status bit 0 = 1) on the byte strobe that brings the transaction count up to the transaction size. txn_end pulses for one cycle after that strobe, but only if config bit 4 was set. With config bit 4 clear, txn_end stays low and the producer still returns to idle.
- R6: When the final byte of a transaction also completes a block, blk_end and txn_end are high in the same cycle.
- R7: The tracker word reads the block byte count in bits [15:0] and the transaction byte count in bits [31:16]. It updates while a transfer runs, and after completion it keeps the final transaction count until the next producer start.
- R8: A start write to a side that is busy has no effect. The counters keep their values and counting continues.
- R9: A consumer-start write received while the consumer is idle makes status bit 16 read 0. Status bit 16 returns to 1 on the cons_byte strobe that brings the consumer count up to the transaction size.
- R10: A write of any value to the soft-reset word returns every register to its R1 value and sends both sides to idle. In the same cycle it overrides a byte strobe, so no pulse follows that strobe.
- R11: Config bits [1:0] select the producer line (1 = prod_req[0], 2 = prod_req[1], 0 or 3 = none). Config bits [3:2] select the consumer line in the same way on cons_req. The selected line is high only while that side is busy.
- R12: Byte strobes that arrive while a side is idle are ignored. The tracker and the pulses do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| prod_byte | input | 1 | One produced byte per cycle while high |
| cons_byte | input | 1 | One consumed byte per cycle while high |
| blk_end | output | 1 | Block boundary pulse |
| txn_end | output | 1 | Transaction completion pulse |
| prod_req | output | 2 | Producer flow-control request lines |
| cons_req | output | 2 | Consumer flow-control request lines |

## Verification
Two cases are hard to reach from the ports, and both depend on exact cycle alignment. The first is a soft-reset write that lands in the same cycle as the byte completing a block. The bench sets this up by programming a 4-byte block, sending exactly three bytes, and then driving the soft-reset write and the fourth strobe on the same edge. The second is the last byte of a transfer also being a block boundary. It is reached with a 2048-byte transfer of 512-byte blocks, and the check is that the two pulses coincide exactly once.

// File: rtl/sband_pkg.sv
package sband_pkg;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_CFG    = 4'd0;
    localparam logic [ADDR_W-1:0] A_STAT   = 4'd1;
    localparam logic [ADDR_W-1:0] A_SRST   = 4'd2;
    localparam logic [ADDR_W-1:0] A_PSTART = 4'd3;
    localparam logic [ADDR_W-1:0] A_CSTART = 4'd4;
    localparam logic [ADDR_W-1:0] A_BLKSZ  = 4'd5;
    localparam logic [ADDR_W-1:0] A_TXNSZ  = 4'd6;
    localparam logic [ADDR_W-1:0] A_TRACK  = 4'd7;
    localparam logic [ADDR_W-1:0] A_PIPEID = 4'd8;
    localparam logic [ADDR_W-1:0] A_PPSIZE = 4'd9;
    localparam logic [ADDR_W-1:0] A_CPSIZE = 4'd10;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_RUN  = 1'b1
    } side_state_t;

    typedef struct packed {
        logic       infinite;
        logic       direct;
        logic       bypass;
        logic       ten_en;
        logic [1:0] csel;
        logic [1:0] psel;
    } cfg_t;
endpackage

// File: rtl/sband_regs.sv
module sband_regs
    import sband_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int PID_W    = 5,
    parameter int PIPE_RST = 4096
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [2*CNT_W-1:0]    reg_wdata,
    output logic [2*CNT_W-1:0]    reg_rdata,
    input  logic                  prod_idle,
    input  logic                  cons_idle,
    input  logic [CNT_W-1:0]      trk_blk,
    input  logic [CNT_W-1:0]      trk_txn,
    output cfg_t                  cfg,
    output logic [CNT_W-1:0]      blk_size,
    output logic [CNT_W-1:0]      txn_size,
    output logic                  soft_rst,
    output logic                  prod_start,
    output logic                  cons_start
);
    localparam int DW = 2 * CNT_W;
    localparam logic [CNT_W-1:0] PIPE_RV = CNT_W'(PIPE_RST);

    logic [PID_W-1:0] pid_prod, pid_cons;
    logic [CNT_W-1:0] psize_prod, psize_cons;
    logic             wr_cfg, wr_blk, wr_txn, wr_pid, wr_pps, wr_cps;

    assign soft_rst   = reg_wr && (reg_addr == A_SRST);
    assign prod_start = reg_wr && (reg_addr == A_PSTART);
    assign cons_start = reg_wr && (reg_addr == A_CSTART);
    assign wr_cfg     = reg_wr && (reg_addr == A_CFG);
    assign wr_blk     = reg_wr && (reg_addr == A_BLKSZ);
    assign wr_txn     = reg_wr && (reg_addr == A_TXNSZ);
    assign wr_pid     = reg_wr && (reg_addr == A_PIPEID);
    assign wr_pps     = reg_wr && (reg_addr == A_PPSIZE);
    assign wr_cps     = reg_wr && (reg_addr == A_CPSIZE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg        <= '0;
            blk_size   <= '0;
            txn_size   <= '0;
            pid_prod   <= '0;
            pid_cons   <= '0;
            psize_prod <= PIPE_RV;
            psize_cons <= PIPE_RV;
        end else if (soft_rst) begin
            cfg        <= '0;
            blk_size   <= '0;
            txn_size   <= '0;
            pid_prod   <= '0;
            pid_cons   <= '0;
            psize_prod <= PIPE_RV;
            psize_cons <= PIPE_RV;
        end else begin
            if (wr_cfg) begin
                cfg.psel     <= reg_wdata[1:0];
                cfg.csel     <= reg_wdata[3:2];
                cfg.ten_en   <= reg_wdata[4];
                cfg.bypass   <= reg_wdata[16];
                cfg.direct   <= reg_wdata[17];
                cfg.infinite <= reg_wdata[18];
            end
            if (wr_blk) blk_size <= reg_wdata[CNT_W-1:0];
            if (wr_txn) txn_size <= reg_wdata[CNT_W-1:0];
            if (wr_pid) begin
                pid_prod <= reg_wdata[PID_W-1:0];
                pid_cons <= reg_wdata[16 +: PID_W];
            end
            if (wr_pps) psize_prod <= reg_wdata[CNT_W-1:0];
            if (wr_cps) psize_cons <= reg_wdata[CNT_W-1:0];
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CFG: begin
                reg_rdata[1:0] = cfg.psel;
                reg_rdata[3:2] = cfg.csel;
                reg_rdata[4]   = cfg.ten_en;
                reg_rdata[16]  = cfg.bypass;
                reg_rdata[17]  = cfg.direct;
                reg_rdata[18]  = cfg.infinite;
            end
            A_STAT: begin
                reg_rdata[0]  = prod_idle;
                reg_rdata[16] = cons_idle;
            end
            A_BLKSZ:  reg_rdata[CNT_W-1:0] = blk_size;
            A_TXNSZ:  reg_rdata[CNT_W-1:0] = txn_size;
            A_TRACK:  reg_rdata = {trk_txn, trk_blk};
            A_PIPEID: begin
                reg_rdata[PID_W-1:0]  = pid_prod;
                reg_rdata[16 +: PID_W] = pid_cons;
            end
            A_PPSIZE: reg_rdata[CNT_W-1:0] = psize_prod;
            A_CPSIZE: reg_rdata[CNT_W-1:0] = psize_cons;
            default:  reg_rdata = '0;
        endcase
    end

    logic unused_wbits;
    assign unused_wbits = ^{reg_wdata[DW-1:21], reg_wdata[15:5]};

    // R10
    srst_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (cfg == '0 && blk_size == '0 && txn_size == '0
                      && psize_prod == PIPE_RV && psize_cons == PIPE_RV));
endmodule

// File: rtl/sband_prod_fsm.sv
module sband_prod_fsm
    import sband_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             start,
    input  logic             byte_stb,
    input  logic [CNT_W-1:0] blk_size,
    input  logic [CNT_W-1:0] txn_size,
    input  logic             ten_en,
    output logic             blk_end,
    output logic             txn_end,
    output logic             busy,
    output logic [CNT_W-1:0] blk_cnt,
    output logic [CNT_W-1:0] txn_cnt
);
    side_state_t state, nxt;
    logic [CNT_W-1:0] blk_nxt, txn_nxt;
    logic             blk_hit, txn_hit;

    assign blk_nxt = blk_cnt + 1'b1;
    assign txn_nxt = txn_cnt + 1'b1;
    assign blk_hit = (blk_nxt == blk_size);
    assign txn_hit = (txn_nxt == txn_size);
    assign busy    = (state == S_RUN);

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: if (start) nxt = S_RUN;
            S_RUN:  if (byte_stb && txn_hit) nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
        if (soft_rst) nxt = S_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_cnt <= '0;
            txn_cnt <= '0;
            blk_end <= 1'b0;
            txn_end <= 1'b0;
        end else begin
            blk_end <= 1'b0;
            txn_end <= 1'b0;
            if (soft_rst) begin
                blk_cnt <= '0;
                txn_cnt <= '0;
            end else begin
                unique case (state)
                    S_IDLE: if (start) begin
                        blk_cnt <= '0;
                        txn_cnt <= '0;
                    end
                    S_RUN: if (byte_stb) begin
                        txn_cnt <= txn_nxt;
                        blk_cnt <= blk_hit ? '0 : blk_nxt;
                        blk_end <= blk_hit;
                        txn_end <= txn_hit && ten_en;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R5
    txn_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txn_end |-> ($past(ten_en) && state == S_IDLE));
    // R4
    blk_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_end |-> (blk_cnt == '0));
    // R8
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RUN && start && !byte_stb && !soft_rst)
        |=> ($stable(txn_cnt) && $stable(blk_cnt) && state == S_RUN));
    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && !start && !soft_rst)
        |=> ($stable(txn_cnt) && !blk_end));
    // R10
    srst_prod_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (state == S_IDLE && txn_cnt == '0 && blk_cnt == '0
                      && !blk_end && !txn_end));
endmodule

// File: rtl/sband_cons_fsm.sv
module sband_cons_fsm
    import sband_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             start,
    input  logic             byte_stb,
    input  logic [CNT_W-1:0] txn_size,
    output logic             busy
);
    side_state_t state, nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;

    assign cnt_nxt = cnt + 1'b1;
    assign busy    = (state == S_RUN);

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: if (start) nxt = S_RUN;
            S_RUN:  if (byte_stb && cnt_nxt == txn_size) nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
        if (soft_rst) nxt = S_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            cnt <= '0;
        else if (soft_rst)                     cnt <= '0;
        else if (state == S_IDLE && start)     cnt <= '0;
        else if (state == S_RUN && byte_stb)   cnt <= cnt_nxt;
    end

    // R9
    cons_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RUN && !byte_stb && !soft_rst) |=> (state == S_RUN && $stable(cnt)));
endmodule

// File: rtl/sband_engine.sv
module sband_engine
    import sband_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int PID_W    = 5,
    parameter int PIPE_RST = 4096
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [3:0]         reg_addr,
    input  logic [2*CNT_W-1:0] reg_wdata,
    output logic [2*CNT_W-1:0] reg_rdata,
    input  logic               prod_byte,
    input  logic               cons_byte,
    output logic               blk_end,
    output logic               txn_end,
    output logic [1:0]         prod_req,
    output logic [1:0]         cons_req
);
    cfg_t             cfg;
    logic [CNT_W-1:0] blk_size, txn_size, trk_blk, trk_txn;
    logic             soft_rst, prod_start, cons_start, prod_busy, cons_busy;

    sband_regs #(.CNT_W(CNT_W), .PID_W(PID_W), .PIPE_RST(PIPE_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .prod_idle(!prod_busy), .cons_idle(!cons_busy),
        .trk_blk(trk_blk), .trk_txn(trk_txn), .cfg(cfg),
        .blk_size(blk_size), .txn_size(txn_size), .soft_rst(soft_rst),
        .prod_start(prod_start), .cons_start(cons_start)
    );

    sband_prod_fsm #(.CNT_W(CNT_W)) u_prod (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .start(prod_start),
        .byte_stb(prod_byte), .blk_size(blk_size), .txn_size(txn_size),
        .ten_en(cfg.ten_en), .blk_end(blk_end), .txn_end(txn_end),
        .busy(prod_busy), .blk_cnt(trk_blk), .txn_cnt(trk_txn)
    );

    sband_cons_fsm #(.CNT_W(CNT_W)) u_cons (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .start(cons_start),
        .byte_stb(cons_byte), .txn_size(txn_size), .busy(cons_busy)
    );

    logic [1:0][1:0] sel;
    logic [1:0]      side_busy;
    logic [1:0][1:0] req;
    assign sel       = {cfg.csel, cfg.psel};
    assign side_busy = {cons_busy, prod_busy};

    for (genvar s = 0; s < 2; s++) begin : g_req
        always_comb begin
            req[s] = 2'b00;
            if (side_busy[s]) begin
                unique case (sel[s])
                    2'd1:    req[s] = 2'b01;
                    2'd2:    req[s] = 2'b10;
                    default: req[s] = 2'b00;
                endcase
            end
        end
    end

    assign prod_req = req[0];
    assign cons_req = req[1];

    // R11
    req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(prod_req) && $onehot0(cons_req));
    // R11
    req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!prod_busy |-> prod_req == 2'b00));
endmodule

// File: tb/sband_engine_bench.sv
module sband_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        prod_byte = 1'b0;
    logic        cons_byte = 1'b0;
    logic        blk_end, txn_end;
    logic [1:0]  prod_req, cons_req;

    int total = 0;
    int bad = 0;
    int n_blk = 0;
    int n_txn = 0;
    int n_both = 0;

    always #4 clk = ~clk;

    sband_engine u_sband_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .prod_byte(prod_byte),
        .cons_byte(cons_byte), .blk_end(blk_end), .txn_end(txn_end),
        .prod_req(prod_req), .cons_req(cons_req)
    );

    always @(negedge clk) begin
        if (blk_end) n_blk = n_blk + 1;
        if (txn_end) n_txn = n_txn + 1;
        if (blk_end && txn_end) n_both = n_both + 1;
    end

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total = total + 1;
        if (got !== exp) begin
            bad = bad + 1;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pbytes(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            prod_byte = 1'b1;
        end
        @(negedge clk);
        prod_byte = 1'b0;
    endtask

    task automatic cbytes(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cons_byte = 1'b1;
        end
        @(negedge clk);
        cons_byte = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(4'd1, v);  chk("R1 status", v, 32'h0001_0001);
        rd(4'd0, v);  chk("R1 config", v, 32'h0);
        rd(4'd5, v);  chk("R1 blksize", v, 32'h0);
        rd(4'd7, v);  chk("R1 tracker", v, 32'h0);
        rd(4'd9, v);  chk("R1 ppsize", v, 32'd4096);
        rd(4'd10, v); chk("R1 cpsize", v, 32'd4096);
    endtask

    task automatic t_regs;
        logic [31:0] v;
        wr(4'd0, 32'hFFFF_FFFF); rd(4'd0, v); chk("R2 config mask", v, 32'h0007_001F);
        wr(4'd8, 32'hFFFF_FFFF); rd(4'd8, v); chk("R2 pipeid mask", v, 32'h001F_001F);
        wr(4'd6, 32'hABCD_1234); rd(4'd6, v); chk("R2 txnsize", v, 32'h0000_1234);
        wr(4'd0, 32'h0);
    endtask

    task automatic t_idle_strobe;
        logic [31:0] v;
        int b0;
        b0 = n_blk;
        wr(4'd5, 32'd1);
        pbytes(5);
        rd(4'd7, v); chk("R12 tracker idle", v, 32'h0);
        chk("R12 no pulse", n_blk - b0, 0);
    endtask

    task automatic t_main;
        logic [31:0] v;
        int b0, t0, c0;
        wr(4'd5, 32'd512);
        wr(4'd6, 32'd2048);
        wr(4'd0, 32'h11);
        b0 = n_blk; t0 = n_txn; c0 = n_both;
        wr(4'd3, 32'h1);
        rd(4'd1, v); chk("R3 busy status", v, 32'h0001_0000);
        chk("R11 prod line X", {30'b0, prod_req}, 32'h1);
        pbytes(700);
        rd(4'd7, v); chk("R7 tracker mid", v, {16'd700, 16'd188});
        pbytes(1348);
        @(negedge clk);
        chk("R4 block pulses", n_blk - b0, 4);
        chk("R5 txn pulse", n_txn - t0, 1);
        chk("R6 coincide", n_both - c0, 1);
        rd(4'd7, v); chk("R7 tracker end", v, {16'd2048, 16'd0});
        rd(4'd1, v); chk("R5 idle after", v, 32'h0001_0001);
        chk("R11 idle lines", {30'b0, prod_req}, 32'h0);
    endtask

    task automatic t_no_ten;
        logic [31:0] v;
        int b0, t0;
        wr(4'd0, 32'h02);
        wr(4'd5, 32'd4);
        wr(4'd6, 32'd8);
        b0 = n_blk; t0 = n_txn;
        wr(4'd3, 32'h1);
        chk("R11 prod line Y", {30'b0, prod_req}, 32'h2);
        pbytes(8);
        @(negedge clk);
        chk("R5 no txn pulse", n_txn - t0, 0);
        chk("R4 blocks small", n_blk - b0, 2);
        rd(4'd1, v); chk("R5 idle no en", v, 32'h0001_0001);
    endtask

    task automatic t_busy_start;
        logic [31:0] v;
        int t0;
        wr(4'd0, 32'h10);
        wr(4'd5, 32'd4);
        wr(4'd6, 32'd10);
        t0 = n_txn;
        wr(4'd3, 32'h1);
        pbytes(3);
        wr(4'd3, 32'h1);
        pbytes(3);
        rd(4'd7, v); chk("R8 restart ignored", v, {16'd6, 16'd2});
        pbytes(4);
        @(negedge clk);
        chk("R8 completes", n_txn - t0, 1);
    endtask

    task automatic t_consumer;
        logic [31:0] v;
        wr(4'd0, 32'h04);
        wr(4'd6, 32'd8);
        wr(4'd4, 32'h1);
        rd(4'd1, v); chk("R9 cons busy", v, 32'h0000_0001);
        chk("R11 cons line X", {30'b0, cons_req}, 32'h1);
        cbytes(7);
        rd(4'd1, v); chk("R9 cons still busy", v, 32'h0000_0001);
        cbytes(1);
        rd(4'd1, v); chk("R9 cons idle", v, 32'h0001_0001);
    endtask

    task automatic t_sreset;
        logic [31:0] v;
        int b0;
        wr(4'd0, 32'h15);
        wr(4'd5, 32'd4);
        wr(4'd6, 32'd100);
        wr(4'd9, 32'd77);
        wr(4'd3, 32'h1);
        wr(4'd4, 32'h1);
        pbytes(3);
        b0 = n_blk;
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'd2; reg_wdata = 32'h0; prod_byte = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; prod_byte = 1'b0;
        @(negedge clk);
        chk("R10 strobe overridden", n_blk - b0, 0);
        rd(4'd7, v); chk("R10 tracker", v, 32'h0);
        rd(4'd1, v); chk("R10 status", v, 32'h0001_0001);
        rd(4'd0, v); chk("R10 config", v, 32'h0);
        rd(4'd9, v); chk("R10 ppsize", v, 32'd4096);
    endtask

    initial begin
        #(8 * 200000);
        bad = bad + 1;
        total = total + 1;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_regs;
        t_idle_strobe;
        t_main;
        t_no_ten;
        t_busy_start;
        t_consumer;
        t_sreset;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule